// File: doc/BRIEF.md
# VLAN Membership Table Command Engine

This block keeps a 16-entry VLAN membership table. Software changes the table only through a 32-bit command register. Each entry holds a 12-bit VLAN ID, a member-port bitmap, a valid bit, a 3-bit priority value and a priority-override enable.

A command starts when the command register is written with its start bit set. It then runs for a fixed number of cycles, and its start bit reads back as 1 until it finishes. The commands are:
- no-op
- clear every entry
- place an entry
- drop the entry that matches a VLAN ID
- take one port out of every entry

A separate data register supplies the member bitmap and the valid bit used by the place command.

Forwarding logic reads the table through a combinational lookup port keyed by VLAN ID. A running command works on a private staging copy of the table and writes all of its changes back in its final cycle. Lookups therefore always see a table that is consistent with completed commands.

Top module: `vlan_cmd_engine`

## Requirements
- R1: After reset the command register reads 0 and every lookup misses (hit, members, priority and enable all 0).
- R2: A command-register write with bit 3 set while idle starts a command. It latches op (bits 2:0), port (bits 11:8), VLAN ID (bits 27:16), priority (bits 30:28) and priority enable (bit 31), all of which read back at the same positions while bit 3 reads 1. A write with bit 3 clear starts nothing and changes nothing.
- R3: Every command keeps bit 3 of the command register at 1 for exactly ENTRIES+1 = 17 clock cycles.
- R4: Writes to the command register or the data register while a command runs are ignored.
- R5: Op 2 (load) writes the VLAN ID, priority and enable from the command, plus members (data bits 9:0) and valid (data bit 11). It overwrites the valid entry with the same VLAN ID if there is one. Otherwise it takes the lowest-indexed invalid entry.
- R6: A load that finds neither a match nor a free entry leaves the table unchanged and sets bit 4 of the command register. Bit 4 is cleared when the next command starts, and only a load can set it.
- R7: Op 3 (purge) invalidates the valid entry whose VLAN ID matches. If nothing matches it has no effect.
- R8: Op 4 (remove-port) clears member bit `port` in every entry. A port number of 10 or more has no effect.
- R9: Op 1 (flush) invalidates every entry.
- R10: The lookup returns hit, members, priority and enable of a valid entry whose VLAN ID equals the lookup VLAN ID; the lowest-indexed one wins if several match. While a command runs, the lookup reflects the table as it was before that command.
- R11: Op 0 (no-op) and the unused op codes 5 to 7 run for the full command time and leave the table unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_we | input | 1 | Command register write strobe |
| cmd_wdata | input | 32 | Command register write value |
| cmd_rdata | output | 32 | Command register read value, with the active and full status bits |
| data_we | input | 1 | Data register write strobe |
| data_wdata | input | 32 | Data register write value (members in bits 9:0, valid in bit 11) |
| lk_vid | input | 12 | Lookup VLAN ID |
| lk_hit | output | 1 | Lookup found a valid entry |
| lk_members | output | 10 | Member bitmap of the matching entry |
| lk_prio | output | 3 | Priority value of the matching entry |
| lk_prio_en | output | 1 | Priority-override enable of the matching entry |

## Verification
The assertions check the following on every cycle:
- a start write makes the engine busy on the next edge;
- each busy period lasts exactly seventeen cycles;
- the latched command fields and the full flag hold still while a command runs;
- full can rise only at the end of a load;
- a lookup held on one VLAN ID returns the same answer for the whole of a command.

Only the bench scenarios can show the effect of each command on the table contents:
- slot choice on load (overwrite versus lowest free slot);
- purge of matching and missing IDs;
- per-port removal, including out-of-range ports;
- flush;
- that data written during a command is dropped.

The bench shows these by sweeping lookups against a model of the table.

// File: rtl/vlan_cmd_engine.sv
module vlan_cmd_engine #(
  parameter int ENTRIES = 16,
  parameter int PORTS   = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_we,
  input  logic [31:0]      cmd_wdata,
  output logic [31:0]      cmd_rdata,
  input  logic             data_we,
  input  logic [31:0]      data_wdata,
  input  logic [11:0]      lk_vid,
  output logic             lk_hit,
  output logic [PORTS-1:0] lk_members,
  output logic [2:0]       lk_prio,
  output logic             lk_prio_en
);
  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
  localparam int CNT_W = $clog2(ENTRIES + 1);
  localparam logic [2:0] OP_FLUSH = 3'd1, OP_LOAD = 3'd2, OP_PURGE = 3'd3, OP_RMPORT = 3'd4;

  logic busy, full, c_pen, d_val;
  logic [2:0] c_op, c_pri;
  logic [11:0] c_vid;
  logic [3:0] c_port;
  logic [PORTS-1:0] d_mem;

  logic             t_val [ENTRIES];
  logic [11:0]      t_vid [ENTRIES];
  logic [PORTS-1:0] t_mem [ENTRIES];
  logic [2:0]       t_pri [ENTRIES];
  logic             t_pen [ENTRIES];
  logic             s_val [ENTRIES];
  logic [11:0]      s_vid [ENTRIES];
  logic [PORTS-1:0] s_mem [ENTRIES];
  logic [2:0]       s_pri [ENTRIES];
  logic             s_pen [ENTRIES];

  logic [CNT_W-1:0] scan;
  logic hit_f, free_f;
  logic [IDX_W-1:0] hit_i, free_i;

  wire start = cmd_we && cmd_wdata[3] && !busy;
  wire [IDX_W-1:0] si = scan[IDX_W-1:0];
  wire [IDX_W-1:0] slot = hit_f ? hit_i : free_i;
  wire [PORTS-1:0] pbit = (32'(c_port) < PORTS) ? (PORTS'(1) << c_port) : '0;

  assign cmd_rdata = {c_pen, c_pri, c_vid, 4'b0, c_port, 3'b0, full, busy, c_op};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0; full <= 1'b0; c_op <= '0; c_pri <= '0; c_pen <= 1'b0;
      c_vid <= '0; c_port <= '0; d_mem <= '0; d_val <= 1'b0;
      scan <= '0; hit_f <= 1'b0; free_f <= 1'b0; hit_i <= '0; free_i <= '0;
      for (int e = 0; e < ENTRIES; e++) begin
        t_val[e] <= 1'b0; t_vid[e] <= '0; t_mem[e] <= '0; t_pri[e] <= '0; t_pen[e] <= 1'b0;
        s_val[e] <= 1'b0; s_vid[e] <= '0; s_mem[e] <= '0; s_pri[e] <= '0; s_pen[e] <= 1'b0;
      end
    end else begin
      if (data_we && !busy) begin
        d_mem <= data_wdata[PORTS-1:0];
        d_val <= data_wdata[11];
      end
      if (start) begin
        busy <= 1'b1; full <= 1'b0; scan <= '0; hit_f <= 1'b0; free_f <= 1'b0;
        c_op <= cmd_wdata[2:0]; c_port <= cmd_wdata[11:8]; c_vid <= cmd_wdata[27:16];
        c_pri <= cmd_wdata[30:28]; c_pen <= cmd_wdata[31];
        for (int e = 0; e < ENTRIES; e++) begin
          s_val[e] <= t_val[e]; s_vid[e] <= t_vid[e]; s_mem[e] <= t_mem[e];
          s_pri[e] <= t_pri[e]; s_pen[e] <= t_pen[e];
        end
      end else if (busy) begin
        if (32'(scan) != ENTRIES) begin
          scan <= scan + 1'b1;
          case (c_op)
            OP_FLUSH:  s_val[si] <= 1'b0;
            OP_PURGE:  if (s_val[si] && s_vid[si] == c_vid) s_val[si] <= 1'b0;
            OP_RMPORT: s_mem[si] <= s_mem[si] & ~pbit;
            OP_LOAD: begin
              if (s_val[si] && s_vid[si] == c_vid && !hit_f) begin
                hit_f <= 1'b1; hit_i <= si;
              end
              if (!s_val[si] && !free_f) begin
                free_f <= 1'b1; free_i <= si;
              end
            end
            default: ;
          endcase
        end else begin
          busy <= 1'b0;
          for (int e = 0; e < ENTRIES; e++) begin
            t_val[e] <= s_val[e]; t_vid[e] <= s_vid[e]; t_mem[e] <= s_mem[e];
            t_pri[e] <= s_pri[e]; t_pen[e] <= s_pen[e];
          end
          if (c_op == OP_LOAD) begin
            if (hit_f || free_f) begin
              t_val[slot] <= d_val; t_vid[slot] <= c_vid; t_mem[slot] <= d_mem;
              t_pri[slot] <= c_pri; t_pen[slot] <= c_pen;
            end else begin
              full <= 1'b1;
            end
          end
        end
      end
    end
  end

  always_comb begin
    lk_hit = 1'b0; lk_members = '0; lk_prio = '0; lk_prio_en = 1'b0;
    for (int e = ENTRIES - 1; e >= 0; e--) begin
      if (t_val[e] && t_vid[e] == lk_vid) begin
        lk_hit = 1'b1; lk_members = t_mem[e]; lk_prio = t_pri[e]; lk_prio_en = t_pen[e];
      end
    end
  end
endmodule

// File: rtl/vlan_cmd_engine_chk.sv
module vlan_cmd_engine_chk #(
  parameter int ENTRIES = 16,
  parameter int PORTS   = 10
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cmd_we,
  input logic [31:0]      cmd_wdata,
  input logic [31:0]      cmd_rdata,
  input logic [11:0]      lk_vid,
  input logic             lk_hit,
  input logic [PORTS-1:0] lk_members,
  input logic [2:0]       lk_prio,
  input logic             lk_prio_en
);
  wire busy = cmd_rdata[3];
  logic [31:0] run_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) run_cnt <= '0;
    else if (busy) run_cnt <= run_cnt + 1;
    else run_cnt <= '0;
  end

  AST_START_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_we && cmd_wdata[3] && !busy) |=> busy); // R2
  AST_SPAN_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> run_cnt < 32'(ENTRIES + 1)); // R3
  AST_SPAN_EXACT: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> run_cnt == 32'(ENTRIES + 1)); // R3
  AST_FIELDS_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> ($stable(cmd_rdata[31:4]) && $stable(cmd_rdata[2:0]))); // R4
  AST_FULL_LOAD_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cmd_rdata[4]) |-> (cmd_rdata[2:0] == 3'd2 && $fell(busy))); // R6
  AST_LOOKUP_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && $stable(lk_vid)) |->
      ($stable(lk_hit) && $stable(lk_members) && $stable(lk_prio) && $stable(lk_prio_en))); // R10
endmodule

bind vlan_cmd_engine vlan_cmd_engine_chk #(.ENTRIES(ENTRIES), .PORTS(PORTS)) chk_i (
  .clk(clk), .rst_n(rst_n), .cmd_we(cmd_we), .cmd_wdata(cmd_wdata), .cmd_rdata(cmd_rdata),
  .lk_vid(lk_vid), .lk_hit(lk_hit), .lk_members(lk_members), .lk_prio(lk_prio),
  .lk_prio_en(lk_prio_en)
);

// File: tb/vlan_cmd_engine_tb_top.sv
module vlan_cmd_engine_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic cmd_we = 1'b0, data_we = 1'b0;
  logic [31:0] cmd_wdata = '0, data_wdata = '0, cmd_rdata;
  logic [11:0] lk_vid = '0;
  logic lk_hit, lk_prio_en;
  logic [9:0] lk_members;
  logic [2:0] lk_prio;

  always #4 clk = ~clk;

  vlan_cmd_engine dut_i (
    .clk(clk), .rst_n(rst_n), .cmd_we(cmd_we), .cmd_wdata(cmd_wdata), .cmd_rdata(cmd_rdata),
    .data_we(data_we), .data_wdata(data_wdata), .lk_vid(lk_vid), .lk_hit(lk_hit),
    .lk_members(lk_members), .lk_prio(lk_prio), .lk_prio_en(lk_prio_en)
  );

  int n_vec = 0, n_bad = 0;
  logic done = 1'b0;

  logic       r_val [16];
  logic [11:0] r_vid [16];
  logic [9:0] r_mem [16];
  logic [2:0] r_pri [16];
  logic       r_pen [16];
  logic [9:0] r_dmem = '0;
  logic       r_dval = 1'b0;
  logic       r_full = 1'b0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [14:0] ref_look(input logic [11:0] v);
    for (int e = 0; e < 16; e++)
      if (r_val[e] && r_vid[e] == v) return {1'b1, r_pen[e], r_pri[e], r_mem[e]};
    return '0;
  endfunction

  task automatic lk_check(input string req, input logic [11:0] v);
    lk_vid = v;
    #1;
    chk(req, 32'({lk_hit, lk_prio_en, lk_prio, lk_members}), 32'(ref_look(v)));
  endtask

  task automatic sweep(input string req);
    for (int v = 0; v < 260; v++) begin
      @(negedge clk);
      lk_check(req, 12'(v));
    end
    @(negedge clk);
    lk_check(req, 12'd777);
    lk_check(req, 12'd778);
    lk_check(req, 12'd4095);
  endtask

  function automatic logic [31:0] mk(input logic [2:0] op, input logic [11:0] vid,
                                     input logic [3:0] port, input logic [2:0] pri, input logic pen);
    return {pen, pri, vid, 4'b0, port, 4'b0, 1'b1, op};
  endfunction

  task automatic set_data(input logic [9:0] m, input logic v);
    @(negedge clk);
    data_we = 1'b1; data_wdata = {20'b0, v, 1'b0, m};
    @(negedge clk);
    data_we = 1'b0;
    r_dmem = m; r_dval = v;
  endtask

  task automatic ref_apply(input logic [31:0] w);
    logic [2:0] op;
    int slot;
    op = w[2:0];
    r_full = 1'b0;
    case (op)
      3'd1: for (int e = 0; e < 16; e++) r_val[e] = 1'b0;
      3'd3: for (int e = 0; e < 16; e++) if (r_val[e] && r_vid[e] == w[27:16]) r_val[e] = 1'b0;
      3'd4: if (w[11:8] < 10) for (int e = 0; e < 16; e++) r_mem[e][w[11:8]] = 1'b0;
      3'd2: begin
        slot = -1;
        for (int e = 15; e >= 0; e--) if (r_val[e] && r_vid[e] == w[27:16]) slot = e;
        if (slot < 0) for (int e = 15; e >= 0; e--) if (!r_val[e]) slot = e;
        if (slot < 0) r_full = 1'b1;
        else begin
          r_val[slot] = r_dval; r_vid[slot] = w[27:16]; r_mem[slot] = r_dmem;
          r_pri[slot] = w[30:28]; r_pen[slot] = w[31];
        end
      end
      default: ;
    endcase
  endtask

  task automatic issue(input string req, input logic [31:0] w);
    int cyc;
    @(negedge clk);
    cmd_we = 1'b1; cmd_wdata = w;
    @(negedge clk);
    cmd_we = 1'b0;
    chk({req, " R2 readback"}, cmd_rdata, w);
    cyc = 0;
    while (cmd_rdata[3]) begin
      cyc++;
      @(negedge clk);
    end
    chk({req, " R3 active span"}, 32'(cyc), 32'd17);
    ref_apply(w);
    chk({req, " R6 full flag"}, 32'(cmd_rdata[4]), 32'(r_full));
  endtask

  initial begin
    for (int i = 0; i < 200000; i++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      n_vec++; n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] w;
    for (int e = 0; e < 16; e++) begin
      r_val[e] = 0; r_vid[e] = 0; r_mem[e] = 0; r_pri[e] = 0; r_pen[e] = 0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 cmd reads zero", cmd_rdata, 32'h0);
    lk_check("R1 lookup misses", 12'd100);

    @(negedge clk);
    cmd_we = 1'b1; cmd_wdata = mk(3'd2, 12'd50, 4'd1, 3'd2, 1'b1) & ~32'h8;
    @(negedge clk);
    cmd_we = 1'b0;
    @(negedge clk);
    chk("R2 no start without bit3", cmd_rdata, 32'h0);

    for (int i = 0; i < 16; i++) begin
      set_data(10'((i * 37 + 5) & 10'h3ff), 1'b1);
      issue("R5 load", mk(3'd2, 12'(100 + i * 7), 4'd0, 3'(i), i[0]));
    end
    sweep("R5 R10 filled table");

    set_data(10'h155, 1'b1);
    issue("R6 load into full table", mk(3'd2, 12'd999, 4'd0, 3'd1, 1'b0));
    lk_check("R6 table unchanged", 12'd999);
    issue("R11 noop", mk(3'd0, 12'd5, 4'd3, 3'd0, 1'b0));
    issue("R11 unused op", mk(3'd6, 12'd100, 4'd3, 3'd0, 1'b0));
    sweep("R11 table unchanged");

    set_data(10'h2aa, 1'b1);
    issue("R5 overwrite", mk(3'd2, 12'd121, 4'd0, 3'd7, 1'b1));
    sweep("R5 overwrite match");

    issue("R7 purge", mk(3'd3, 12'd135, 4'd0, 3'd0, 1'b0));
    issue("R7 purge absent", mk(3'd3, 12'd3000, 4'd0, 3'd0, 1'b0));
    sweep("R7 after purge");
    set_data(10'h0f0, 1'b1);
    issue("R5 reuse free slot", mk(3'd2, 12'd777, 4'd0, 3'd4, 1'b0));
    issue("R6 full again", mk(3'd2, 12'd778, 4'd0, 3'd4, 1'b0));
    sweep("R5 R6 slot reuse");

    w = mk(3'd4, 12'd0, 4'd2, 3'd0, 1'b0);
    @(negedge clk);
    cmd_we = 1'b1; cmd_wdata = w;
    @(negedge clk);
    cmd_we = 1'b0;
    for (int k = 0; k < 4; k++) lk_check("R10 old state while active", 12'(100 + k * 7));
    @(negedge clk);
    cmd_we = 1'b1; cmd_wdata = mk(3'd1, 12'd9, 4'd0, 3'd0, 1'b0);
    data_we = 1'b1; data_wdata = 32'h0000_0bff;
    @(negedge clk);
    cmd_we = 1'b0; data_we = 1'b0;
    chk("R4 cmd write ignored", cmd_rdata, w);
    while (cmd_rdata[3]) @(negedge clk);
    ref_apply(w);
    sweep("R4 R8 after remove with ignored writes");
    issue("R7 purge for R4", mk(3'd3, 12'd100, 4'd0, 3'd0, 1'b0));
    issue("R4 data kept", mk(3'd2, 12'd250, 4'd0, 3'd3, 1'b1));
    lk_check("R4 load used earlier data", 12'd250);

    for (int p = 0; p < 16; p++) begin
      issue("R8 remove port", mk(3'd4, 12'd0, 4'(p), 3'd0, 1'b0));
      for (int i = 0; i < 16; i++) lk_check("R8 members", 12'(100 + i * 7));
      lk_check("R8 members", 12'd777);
      lk_check("R8 members", 12'd250);
    end

    issue("R9 flush", mk(3'd1, 12'd0, 4'd0, 3'd0, 1'b0));
    sweep("R9 all invalid");

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule